// File: doc/BRIEF.md
# String Store Address Generator

This block turns one element of a store-string operation into a memory write request. It receives the decoded opcode class, the operand-size and address-size attributes, the 64-bit-mode flag, the REX.W flag, the direction flag, the extra-segment base, the destination index value and the accumulator value. From these it produces the effective address, the byte-enable mask and the lane-aligned write data for an 8-byte data bus. It also produces the updated destination index. Encodings that cannot occur in the current mode are flagged. Repeat counting, paging and segment limit checks are handled outside the block.

Requests enter on a valid/ready handshake and leave through a single output register that has its own valid/ready handshake. An input is accepted on a rising clock edge when `in_valid` and `in_ready` are both high, and its result appears in the following cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and `in_ready` stays low. Back-pressure therefore stalls the producer without losing a request.

Top module: `ss_store_agen`

## Requirements
- R1: When `op_wide` is 0 (the byte opcode), the element is 1 byte, taken from `acc[7:0]`. `rex_w` and `opsz16` have no effect on it.
- R2: When `op_wide` is 1 and `rex_w` is 0, the element is 2 bytes (`acc[15:0]`) if `opsz16` is 1, and 4 bytes (`acc[31:0]`) if `opsz16` is 0.
- R3: When `op_wide` is 1 and `rex_w` is 1 in 64-bit mode, the element is all 8 bytes of `acc`. The same combination outside 64-bit mode raises `bad_enc`. Any request with `bad_enc` set has `byte_en` equal to 0 and `idx_next` equal to `idx_in`.
- R4: Outside 64-bit mode, `eff_addr` equals `es_base[31:0]` plus the index, modulo 2^32, zero-extended to 64 bits. The index is `idx_in[15:0]` when `asz` is 0 (16-bit) and `idx_in[31:0]` when `asz` is 1 (32-bit).
- R5: In 64-bit mode, `es_base` is ignored. `eff_addr` is `idx_in` when `asz` is 2 (64-bit), and `idx_in[31:0]` zero-extended when `asz` is 1.
- R6: With `dir_flag` 0 the index advances by the element size (1, 2, 4 or 8). With `dir_flag` 1 it retreats by the same amount.
- R7: With 16-bit addressing, only `idx_next[15:0]` changes, and it wraps modulo 2^16. With 32-bit addressing outside 64-bit mode, only the low 32 bits change, wrapping modulo 2^32, and the upper bits are kept. With 32-bit addressing in 64-bit mode, the 32-bit result is zero-extended.
- R8: Let `k = eff_addr[2:0]` and let `n` be the element size in bytes. For a legal request, `byte_en` is ((2^n)-1) shifted left by `k`, keeping only bits 7:0. `wr_data` is the element value shifted left by 8*`k` bits, keeping only the low 64 bits.
- R9: `bad_enc` is raised in each of these cases: `asz` is 3; `asz` is 2 outside 64-bit mode; `asz` is 0 in 64-bit mode.
- R10: `in_ready` equals (not `out_valid`) or `out_ready`. A request accepted at one clock edge is presented with `out_valid` high after that edge. While the output is stalled, all outputs are held unchanged.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| op_wide | input | 1 | 0: byte store opcode, 1: word/dword/qword store opcode |
| opsz16 | input | 1 | Operand-size attribute is 16 bits |
| asz | input | 2 | Address size: 0 = 16, 1 = 32, 2 = 64, 3 = reserved |
| mode64 | input | 1 | Processor is in 64-bit mode |
| rex_w | input | 1 | REX.W present |
| dir_flag | input | 1 | Direction flag |
| es_base | input | 64 | Extra-segment base |
| idx_in | input | 64 | Destination index register value |
| acc | input | 64 | Accumulator value |
| out_valid | output | 1 | Write request valid |
| out_ready | input | 1 | Consumer accepts the request |
| eff_addr | output | 64 | Effective (linear) address |
| byte_en | output | 8 | Byte lanes written |
| wr_data | output | 64 | Lane-aligned write data |
| idx_next | output | 64 | Updated destination index |
| bad_enc | output | 1 | Encoding illegal in the current mode |

## Verification
The bench sweeps every combination of opcode class, operand size, address size, mode, REX.W and direction. Each combination is tried against index values at zero, at all ones, at a 16-bit boundary and at odd offsets, with segment bases that do and do not wrap past 2^32. The all-ones and boundary indices separate correct 16-bit and 32-bit wrapping from a full-width update. The odd low address bits separate correct lane shifting from aligned-only placement. The wrapping base separates the 32-bit sum used outside 64-bit mode from a base that 64-bit mode must ignore. A separate stall sequence holds `out_ready` low while a second request waits, and checks that the output holds and that the waiting request is taken once the stall ends.

// File: rtl/ss_store_pkg.sv
package ss_store_pkg;
  typedef enum logic [1:0] {
    ASZ_16   = 2'd0,
    ASZ_32   = 2'd1,
    ASZ_64   = 2'd2,
    ASZ_RSVD = 2'd3
  } asz_e;
endpackage

// File: rtl/ss_size_dec.sv
module ss_size_dec
  import ss_store_pkg::*;
(
  input  logic       op_wide,
  input  logic       opsz16,
  input  logic       rex_w,
  input  logic       mode64,
  input  asz_e       asz,
  output logic [1:0] lg_size,
  output logic       bad
);
  logic rexw_bad, asz_bad;

  always_comb begin
    if (!op_wide)    lg_size = 2'd0;
    else if (rex_w)  lg_size = 2'd3;
    else if (opsz16) lg_size = 2'd1;
    else             lg_size = 2'd2;
  end

  assign rexw_bad = op_wide && rex_w && !mode64;

  always_comb begin
    case (asz)
      ASZ_16:  asz_bad = mode64;
      ASZ_32:  asz_bad = 1'b0;
      ASZ_64:  asz_bad = !mode64;
      default: asz_bad = 1'b1;
    endcase
  end

  assign bad = rexw_bad || asz_bad;
endmodule

// File: rtl/ss_index_unit.sv
module ss_index_unit
  import ss_store_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  asz_e            asz,
  input  logic            mode64,
  input  logic            dir_flag,
  input  logic [1:0]      lg_size,
  input  logic [XLEN-1:0] es_base,
  input  logic [XLEN-1:0] idx_in,
  output logic [XLEN-1:0] eff_addr,
  output logic [XLEN-1:0] idx_next
);
  localparam int HALF = XLEN / 2;
  localparam int NARROW = 16;

  logic [XLEN-1:0] idx_eff, step, moved;
  logic [HALF-1:0] seg_sum;

  always_comb begin
    case (asz)
      ASZ_16:  idx_eff = {{(XLEN-NARROW){1'b0}}, idx_in[NARROW-1:0]};
      ASZ_32:  idx_eff = {{(XLEN-HALF){1'b0}}, idx_in[HALF-1:0]};
      default: idx_eff = idx_in;
    endcase
  end

  assign step  = XLEN'(1) << lg_size;
  assign moved = dir_flag ? (idx_eff - step) : (idx_eff + step);

  always_comb begin
    case (asz)
      ASZ_16:  idx_next = {idx_in[XLEN-1:NARROW], moved[NARROW-1:0]};
      ASZ_32:  idx_next = mode64 ? {{(XLEN-HALF){1'b0}}, moved[HALF-1:0]}
                                 : {idx_in[XLEN-1:HALF], moved[HALF-1:0]};
      default: idx_next = moved;
    endcase
  end

  assign seg_sum  = es_base[HALF-1:0] + idx_eff[HALF-1:0];
  assign eff_addr = mode64 ? idx_eff : {{(XLEN-HALF){1'b0}}, seg_sum};
endmodule

// File: rtl/ss_lane_align.sv
module ss_lane_align #(
  parameter int XLEN      = 64,
  parameter int BUS_BYTES = 8,
  localparam int OFF_W    = $clog2(BUS_BYTES)
) (
  input  logic [1:0]           lg_size,
  input  logic [OFF_W-1:0]     off,
  input  logic [XLEN-1:0]      acc,
  input  logic                 kill,
  output logic [BUS_BYTES-1:0] byte_en,
  output logic [XLEN-1:0]      wr_data
);
  logic [BUS_BYTES-1:0]   size_mask;
  logic [2*BUS_BYTES-1:0] wide_en;
  logic [XLEN-1:0]        val;

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    assign size_mask[i]    = (i < (1 << lg_size));
    assign val[8*i +: 8]   = size_mask[i] ? acc[8*i +: 8] : 8'h00;
  end

  assign wide_en = {{BUS_BYTES{1'b0}}, size_mask} << off;
  assign byte_en = kill ? '0 : wide_en[BUS_BYTES-1:0];
  assign wr_data = val << {off, 3'b000};
endmodule

// File: rtl/ss_store_agen.sv
module ss_store_agen
  import ss_store_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int BUS_BYTES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 op_wide,
  input  logic                 opsz16,
  input  logic [1:0]           asz,
  input  logic                 mode64,
  input  logic                 rex_w,
  input  logic                 dir_flag,
  input  logic [XLEN-1:0]      es_base,
  input  logic [XLEN-1:0]      idx_in,
  input  logic [XLEN-1:0]      acc,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [XLEN-1:0]      eff_addr,
  output logic [BUS_BYTES-1:0] byte_en,
  output logic [XLEN-1:0]      wr_data,
  output logic [XLEN-1:0]      idx_next,
  output logic                 bad_enc
);
  localparam int OFF_W = $clog2(BUS_BYTES);

  asz_e                 asz_t;
  logic [1:0]           lg_size;
  logic                 bad_c;
  logic [XLEN-1:0]      addr_c, next_c, data_c;
  logic [BUS_BYTES-1:0] en_c;
  logic                 load;

  assign asz_t = asz_e'(asz);

  ss_size_dec u_size (
    .op_wide (op_wide),
    .opsz16  (opsz16),
    .rex_w   (rex_w),
    .mode64  (mode64),
    .asz     (asz_t),
    .lg_size (lg_size),
    .bad     (bad_c)
  );

  ss_index_unit #(.XLEN(XLEN)) u_index (
    .asz      (asz_t),
    .mode64   (mode64),
    .dir_flag (dir_flag),
    .lg_size  (lg_size),
    .es_base  (es_base),
    .idx_in   (idx_in),
    .eff_addr (addr_c),
    .idx_next (next_c)
  );

  ss_lane_align #(.XLEN(XLEN), .BUS_BYTES(BUS_BYTES)) u_lane (
    .lg_size (lg_size),
    .off     (addr_c[OFF_W-1:0]),
    .acc     (acc),
    .kill    (bad_c),
    .byte_en (en_c),
    .wr_data (data_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      eff_addr  <= '0;
      byte_en   <= '0;
      wr_data   <= '0;
      idx_next  <= '0;
      bad_enc   <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      eff_addr  <= addr_c;
      byte_en   <= en_c;
      wr_data   <= data_c;
      idx_next  <= bad_c ? idx_in : next_c;
      bad_enc   <= bad_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(eff_addr) && $stable(byte_en)
      && $stable(wr_data) && $stable(idx_next) && $stable(bad_enc)); // R10

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R11

  AST_BAD_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && bad_enc |-> byte_en == '0); // R3

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    load && !op_wide |=> $countones(byte_en) <= 1); // R1

  AST_GOOD_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !bad_enc && eff_addr[OFF_W-1:0] == '0 |-> byte_en[0]); // R8

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid); // R10
endmodule

// File: tb/tb_ss_store_agen.sv
module tb_ss_store_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic        op_wide = 1'b0, opsz16 = 1'b0, mode64 = 1'b0, rex_w = 1'b0, dir_flag = 1'b0;
  logic [1:0]  asz = 2'd0;
  logic [63:0] es_base = '0, idx_in = '0, acc = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [63:0] eff_addr, wr_data, idx_next;
  logic [7:0]  byte_en;
  logic        bad_enc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ss_store_agen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_wide(op_wide), .opsz16(opsz16), .asz(asz), .mode64(mode64),
    .rex_w(rex_w), .dir_flag(dir_flag), .es_base(es_base), .idx_in(idx_in),
    .acc(acc), .out_valid(out_valid), .out_ready(out_ready),
    .eff_addr(eff_addr), .byte_en(byte_en), .wr_data(wr_data),
    .idx_next(idx_next), .bad_enc(bad_enc)
  );

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic send_one(bit w, bit o16, bit [1:0] a, bit m64, bit rw, bit d,
                          logic [63:0] es, logic [63:0] ix, logic [63:0] ac);
    int          nb;
    bit          bad;
    logic [63:0] ex_idx, ex_addr, ex_data;
    logic [31:0] lo32;
    logic [15:0] lo16;
    logic [7:0]  ex_en;
    logic [127:0] wide;
    int          k;
    string       stag, atag, itag, btag;

    @(negedge clk);
    op_wide = w; opsz16 = o16; asz = a; mode64 = m64; rex_w = rw; dir_flag = d;
    es_base = es; idx_in = ix; acc = ac; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;

    nb   = !w ? 1 : (rw ? 8 : (o16 ? 2 : 4));
    stag = !w ? "R1" : (rw ? "R3" : "R2");
    bad  = (w && rw && !m64) || (a == 2'd3) || (a == 2'd2 && !m64) || (a == 2'd0 && m64);
    btag = ((a == 2'd3) || (a == 2'd2 && !m64) || (a == 2'd0 && m64)) ? "R9" : "R3";

    if (m64) begin
      ex_addr = (a == 2'd1) ? {32'h0, ix[31:0]} : ix;
      atag = "R5";
    end else begin
      ex_addr = {32'h0, es[31:0] + ((a == 2'd0) ? {16'h0, ix[15:0]} : ix[31:0])};
      atag = "R4";
    end

    case (a)
      2'd0: begin
        lo16 = d ? ix[15:0] - 16'(nb) : ix[15:0] + 16'(nb);
        ex_idx = {ix[63:16], lo16};
        itag = "R7";
      end
      2'd1: begin
        lo32 = d ? ix[31:0] - 32'(nb) : ix[31:0] + 32'(nb);
        ex_idx = m64 ? {32'h0, lo32} : {ix[63:32], lo32};
        itag = "R7";
      end
      default: begin
        ex_idx = d ? ix - 64'(nb) : ix + 64'(nb);
        itag = "R6";
      end
    endcase
    if (bad) ex_idx = ix;

    k = int'(ex_addr[2:0]);
    ex_en = 8'(((16'd1 << nb) - 16'd1) << k);
    wide = (nb == 8) ? {64'h0, ac} : {64'h0, ac & ((64'd1 << (8 * nb)) - 64'd1)};
    wide = wide << (8 * k);
    ex_data = wide[63:0];

    chk("R10", "out_valid", {63'h0, out_valid}, 64'd1);
    chk(btag, "bad_enc", {63'h0, bad_enc}, {63'h0, bad});
    chk(bad ? "R3" : itag, "idx_next", idx_next, ex_idx);
    if (bad) begin
      chk("R3", "byte_en", {56'h0, byte_en}, 64'h0);
    end else begin
      chk(atag, "eff_addr", eff_addr, ex_addr);
      chk("R8", "byte_en", {56'h0, byte_en}, {56'h0, ex_en});
      chk(stag, "wr_data", wr_data, ex_data);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] idx_set [5];
    logic [63:0] es_set  [2];
    logic [63:0] hold_addr, hold_idx;
    idx_set[0] = 64'h0000_0000_0000_0000;
    idx_set[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    idx_set[2] = 64'h1234_5678_9ABC_DEF3;
    idx_set[3] = 64'hAAAA_0001_0000_FFFE;
    idx_set[4] = 64'h0000_0000_0000_0005;
    es_set[0]  = 64'h0000_0000_0000_0000;
    es_set[1]  = 64'h5555_0000_FFFF_F001;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "out_valid after reset", {63'h0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "out_valid idle", {63'h0, out_valid}, 64'd0);
    chk("R11", "in_ready idle", {63'h0, in_ready}, 64'd1);

    for (int cfg = 0; cfg < 128; cfg++) begin
      for (int ii = 0; ii < 5; ii++) begin
        for (int ei = 0; ei < 2; ei++) begin
          send_one(cfg[0], cfg[1], cfg[3:2], cfg[4], cfg[5], cfg[6],
                   es_set[ei], idx_set[ii], idx_set[ii] ^ 64'hF1E2_D3C4_B5A6_9788);
        end
      end
    end

    // R10 stall: hold out_ready low, second request must wait
    @(negedge clk);
    out_ready = 1'b0;
    op_wide = 1'b1; opsz16 = 1'b0; asz = 2'd2; mode64 = 1'b1; rex_w = 1'b1; dir_flag = 1'b0;
    idx_in = 64'h0000_0000_0000_1003; acc = 64'h0123_4567_89AB_CDEF; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hold_addr = eff_addr;
    hold_idx  = idx_next;
    chk("R10", "out_valid after accept", {63'h0, out_valid}, 64'd1);
    chk("R10", "in_ready during stall", {63'h0, in_ready}, 64'd0);
    idx_in = 64'h0000_0000_0000_2000; dir_flag = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "eff_addr held", eff_addr, hold_addr);
    chk("R10", "idx_next held", idx_next, hold_idx);
    chk("R10", "idx_next first", idx_next, 64'h0000_0000_0000_100B);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "second taken addr", eff_addr, 64'h0000_0000_0000_2000);
    chk("R6", "second idx_next", idx_next, 64'h0000_0000_0000_1FF8);
    @(posedge clk);
    @(negedge clk);
    chk("R10", "drained", {63'h0, out_valid}, 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule